// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the configuration of a small set of hardware breakpoint and watchpoint triggers. Software reaches the triggers indirectly. A select register names one trigger. A control register and a compare register then read and write that trigger's settings. The address comparison, chaining and match actions live elsewhere. This block only stores what they consume.

From the stored settings the bank derives three flags for the memory pipeline. The flags say whether any trigger watches instruction fetch, loads or stores. It also raises a one-cycle request to flush the translation cache whenever a trigger's control word changes. The flags are refreshed on every accepted control write, so the pipeline can skip trigger checks on the kinds of access that no trigger watches.

Top module: `trig_bank`

## Requirements
- R1: After reset the select register reads 0. Every trigger's compare value reads 0. Every control read shows only the read-only fields: type 2 in the top four bits and the mask-maximum value (parameter, default 0) in the six bits below. The fetch, load and store flags and the flush request are all 0.
- R2: The select register stores any written XLEN-bit value and reads it back unchanged.
- R3: A control write stores these fields, and a control read returns them in the same places: load bit 0, store bit 1, execute bit 2, user enable bit 3, supervisor enable bit 4, hypervisor enable bit 5, machine enable bit 6, match mode bits 10:7, chain bit 11, action bits 15:12, select bit 16. Every other bit below the mask-maximum field reads 0.
- R4: The type field and the mask-maximum field cannot be written. Control writes never change them.
- R5: A compare write stores the full XLEN-bit value for the selected trigger, and a compare read returns it unchanged.
- R6: Control and compare writes change only the trigger named by the select register. Every other trigger keeps its contents.
- R7: When the select value is equal to or above the trigger count, control and compare reads return 0. Writes to either register change no trigger, leave the flags as they were and raise no flush request.
- R8: The fetch flag equals the OR of all triggers' execute bits. It is updated by each accepted control write and is valid in the cycle after that write.
- R9: The load flag and the store flag equal the OR of all triggers' load bits and store bits, updated and timed the same way as the fetch flag.
- R10: The flush request is high for exactly the one cycle after each accepted control write. Select and compare writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register named by wr_target |
| wr_target | input | 2 | Register written: 0 select, 1 control, 2 compare, 3 none |
| wr_data | input | XLEN | Write value |
| rd_target | input | 2 | Register read: 0 select, 1 control, 2 compare, 3 reads 0 |
| rd_data | output | XLEN | Combinational read value |
| chk_fetch | output | 1 | Some trigger watches instruction fetch |
| chk_load | output | 1 | Some trigger watches loads |
| chk_store | output | 1 | Some trigger watches stores |
| flush_req | output | 1 | One-cycle translation-cache flush request |

## Verification
The assertions check several behaviours on every cycle. The flush request must follow exactly the accepted control writes. The flags must hold still without such a write. An out-of-range select must read zero. A trigger's stored fields must change only on a write aimed at that trigger. The type field must always read back as 2. Other behaviours only the bench scenarios can show: the bit placement of each control field, the full-width storage of compare values and select values, and that the flags equal the OR across all triggers. The bench shows these by writing chosen patterns into chosen triggers and checking them against its own model of the register contents.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Writable control fields; packed MSB first so bit 0 is the load enable.
  typedef struct packed {
    logic       sel_data;
    logic [3:0] action;
    logic       chain;
    logic [3:0] match_mode;
    logic       en_m;
    logic       en_h;
    logic       en_s;
    logic       en_u;
    logic       execute;
    logic       store;
    logic       load;
  } trig_ctl_t;

  localparam int CTL_W     = $bits(trig_ctl_t);
  localparam int TYPE_W    = 4;
  localparam int MMAX_W    = 6;
  localparam logic [TYPE_W-1:0] TYPE_VAL = 4'd2;

  typedef enum logic [1:0] {
    REG_SEL  = 2'd0,
    REG_CTL  = 2'd1,
    REG_CMP  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  function automatic trig_ctl_t ctl_from_word(input logic [CTL_W-1:0] w);
    return trig_ctl_t'(w);
  endfunction

  function automatic logic [CTL_W-1:0] word_from_ctl(input trig_ctl_t c);
    return CTL_W'(c);
  endfunction

endpackage

// File: rtl/trig_slot.sv
module trig_slot
  import trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctl,
  input  logic            wr_cmp,
  input  logic [XLEN-1:0] wdata,
  output trig_ctl_t       ctl_q,
  output trig_ctl_t       ctl_d,
  output logic [XLEN-1:0] cmp_q
);

  assign ctl_d = wr_ctl ? ctl_from_word(wdata[CTL_W-1:0]) : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (wr_cmp) cmp_q <= wdata;
    end
  end

  // R6: untargeted trigger keeps its contents
  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_q));
  assert_cmp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmp |=> $stable(cmp_q));

endmodule

// File: rtl/trig_flags.sv
module trig_flags #(
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [NTRIG-1:0] exec_nxt,
  input  logic [NTRIG-1:0] load_nxt,
  input  logic [NTRIG-1:0] store_nxt,
  output logic             chk_fetch,
  output logic             chk_load,
  output logic             chk_store
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_fetch <= 1'b0;
      chk_load  <= 1'b0;
      chk_store <= 1'b0;
    end else if (update) begin
      chk_fetch <= |exec_nxt;
      chk_load  <= |load_nxt;
      chk_store <= |store_nxt;
    end
  end

  // R8 / R9: flags move only on an accepted control write
  assert_flags_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable({chk_fetch, chk_load, chk_store}));

endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
#(
  parameter int                XLEN     = 32,
  parameter int                NTRIG    = 4,
  parameter logic [MMAX_W-1:0] MASK_MAX = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_target,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      rd_target,
  output logic [XLEN-1:0] rd_data,
  output logic            chk_fetch,
  output logic            chk_load,
  output logic            chk_store,
  output logic            flush_req
);

  localparam int IDX_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam int PAD_W = XLEN - TYPE_W - MMAX_W - CTL_W;

  logic [XLEN-1:0]  sel_q;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_in_range;
  logic             ctl_wr_ok;
  logic             cmp_wr_ok;

  trig_ctl_t        ctl_q [NTRIG];
  trig_ctl_t        ctl_d [NTRIG];
  logic [XLEN-1:0]  cmp_q [NTRIG];
  logic [NTRIG-1:0] exec_nxt, load_nxt, store_nxt;

  assign sel_idx      = sel_q[IDX_W-1:0];
  assign sel_in_range = (sel_q < XLEN'(NTRIG));
  assign ctl_wr_ok    = wr_en && (wr_target == REG_CTL) && sel_in_range;
  assign cmp_wr_ok    = wr_en && (wr_target == REG_CMP) && sel_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      flush_req <= 1'b0;
    end else begin
      if (wr_en && wr_target == REG_SEL) sel_q <= wr_data;
      flush_req <= ctl_wr_ok;
    end
  end

  for (genvar i = 0; i < NTRIG; i++) begin : g_slot
    logic hit;
    assign hit = (sel_idx == IDX_W'(i));
    trig_slot #(.XLEN(XLEN)) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ctl (ctl_wr_ok && hit),
      .wr_cmp (cmp_wr_ok && hit),
      .wdata  (wr_data),
      .ctl_q  (ctl_q[i]),
      .ctl_d  (ctl_d[i]),
      .cmp_q  (cmp_q[i])
    );
    assign exec_nxt[i]  = ctl_d[i].execute;
    assign load_nxt[i]  = ctl_d[i].load;
    assign store_nxt[i] = ctl_d[i].store;
  end

  trig_flags #(.NTRIG(NTRIG)) flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .update    (ctl_wr_ok),
    .exec_nxt  (exec_nxt),
    .load_nxt  (load_nxt),
    .store_nxt (store_nxt),
    .chk_fetch (chk_fetch),
    .chk_load  (chk_load),
    .chk_store (chk_store)
  );

  logic [XLEN-1:0] ctl_rd_word;
  assign ctl_rd_word = {TYPE_VAL, MASK_MAX, {PAD_W{1'b0}}, word_from_ctl(ctl_q[sel_idx])};

  always_comb begin
    case (reg_sel_e'(rd_target))
      REG_SEL: rd_data = sel_q;
      REG_CTL: rd_data = sel_in_range ? ctl_rd_word   : '0;
      REG_CMP: rd_data = sel_in_range ? cmp_q[sel_idx] : '0;
      default: rd_data = '0;
    endcase
  end

  // R10: flush follows accepted control writes exactly
  assert_flush_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_ok |=> flush_req);
  assert_flush_only_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_ok |=> !flush_req);
  // R7: out-of-range select reads zero
  assert_oor_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_in_range && (rd_target == REG_CTL || rd_target == REG_CMP)) |-> (rd_data == '0));
  // R4: type field always reads 2
  assert_type_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in_range && rd_target == REG_CTL) |-> (rd_data[XLEN-1 -: TYPE_W] == 4'd2));

endmodule

// File: tb/trig_bank_tb_top.sv
`timescale 1ns/1ps
module trig_bank_tb_top;

  localparam int XLEN  = 32;
  localparam int NTRIG = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_target = 2'd3;
  logic [XLEN-1:0] wr_data = '0;
  logic [1:0]      rd_target = 2'd3;
  logic [XLEN-1:0] rd_data;
  logic            chk_fetch, chk_load, chk_store, flush_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [16:0]     m_ctl [NTRIG];
  logic [XLEN-1:0] m_cmp [NTRIG];
  logic [XLEN-1:0] m_sel;

  always #2 clk = ~clk;

  trig_bank #(.XLEN(XLEN), .NTRIG(NTRIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_target(wr_target),
    .wr_data(wr_data), .rd_target(rd_target), .rd_data(rd_data),
    .chk_fetch(chk_fetch), .chk_load(chk_load), .chk_store(chk_store),
    .flush_req(flush_req)
  );

  function automatic logic [XLEN-1:0] exp_ctl_word(input logic [16:0] f);
    return {4'd2, 6'd0, 5'd0, f};
  endfunction

  function automatic logic [2:0] exp_flags();
    logic [2:0] r = '0;
    for (int i = 0; i < NTRIG; i++) r |= {m_ctl[i][2], m_ctl[i][0], m_ctl[i][1]};
    return r;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] tgt, input logic [XLEN-1:0] d);
    wr_en = 1'b1; wr_target = tgt; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_target = 2'd3;
    if (tgt == 2'd0) m_sel = d;
    else if (m_sel < NTRIG) begin
      if (tgt == 2'd1) m_ctl[m_sel] = d[16:0];
      if (tgt == 2'd2) m_cmp[m_sel] = d;
    end
  endtask

  task automatic rd(input logic [1:0] tgt, output logic [XLEN-1:0] v);
    rd_target = tgt;
    #0.5;
    v = rd_data;
  endtask

  task automatic check_trig(input string req, input int i);
    logic [XLEN-1:0] v;
    wr(2'd0, XLEN'(i));
    rd(2'd1, v); check(req, v, exp_ctl_word(m_ctl[i]));
    rd(2'd2, v); check(req, v, m_cmp[i]);
  endtask

  task automatic check_flags(input string req);
    check(req, XLEN'({chk_fetch, chk_load, chk_store}), XLEN'(exp_flags()));
  endtask

  task automatic t_reset();
    logic [XLEN-1:0] v;
    rd(2'd0, v); check("R1 select", v, '0);
    for (int i = 0; i < NTRIG; i++) check_trig("R1 trigger", i);
    check("R1 flags", XLEN'({chk_fetch, chk_load, chk_store, flush_req}), '0);
  endtask

  task automatic t_select();
    logic [XLEN-1:0] v;
    wr(2'd0, 32'hDEAD_BEEF); rd(2'd0, v); check("R2 select wide", v, 32'hDEAD_BEEF);
    wr(2'd0, 32'd3);         rd(2'd0, v); check("R2 select small", v, 32'd3);
  endtask

  task automatic t_ctl_fields();
    logic [XLEN-1:0] v;
    wr(2'd0, 32'd1);
    wr(2'd1, 32'h0001_5A5A); rd(2'd1, v); check("R3 pattern A", v, exp_ctl_word(17'h15A5A));
    wr(2'd1, 32'h0000_A5A5); rd(2'd1, v); check("R3 pattern B", v, exp_ctl_word(17'h0A5A5));
    wr(2'd1, 32'h0001_0000); rd(2'd1, v); check("R3 select bit16", v, 32'h2001_0000);
  endtask

  task automatic t_readonly();
    logic [XLEN-1:0] v;
    wr(2'd0, 32'd0);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R4 all ones", v, 32'h2001_FFFF);
    wr(2'd1, 32'hDFFE_0000); rd(2'd1, v); check("R4 high only", v, 32'h2000_0000);
  endtask

  task automatic t_compare();
    logic [XLEN-1:0] v;
    wr(2'd0, 32'd2);
    wr(2'd2, 32'h8765_4321); rd(2'd2, v); check("R5 compare", v, 32'h8765_4321);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R5 compare ones", v, 32'hFFFF_FFFF);
    check("R10 no flush on compare", XLEN'(flush_req), '0);
  endtask

  task automatic t_isolation();
    for (int i = 0; i < NTRIG; i++) begin
      wr(2'd0, XLEN'(i));
      wr(2'd1, XLEN'(32'h100 * (i + 1) + i));
      wr(2'd2, 32'hC0DE_0000 + XLEN'(i));
    end
    for (int i = 0; i < NTRIG; i++) check_trig("R6 isolation", i);
  endtask

  task automatic t_out_of_range();
    logic [XLEN-1:0] v;
    logic [2:0] fl;
    fl = {chk_fetch, chk_load, chk_store};
    wr(2'd0, XLEN'(NTRIG));
    rd(2'd1, v); check("R7 ctl reads zero", v, '0);
    rd(2'd2, v); check("R7 cmp reads zero", v, '0);
    wr(2'd1, 32'h0000_0007);
    check("R7 no flush", XLEN'(flush_req), '0);
    check("R7 flags kept", XLEN'({chk_fetch, chk_load, chk_store}), XLEN'(fl));
    wr(2'd2, 32'h1234_5678);
    wr(2'd0, 32'h8000_0000);
    rd(2'd1, v); check("R7 far ctl zero", v, '0);
    rd(2'd2, v); check("R7 far cmp zero", v, '0);
    for (int i = 0; i < NTRIG; i++) check_trig("R7 untouched", i);
  endtask

  task automatic t_flags();
    for (int i = 0; i < NTRIG; i++) begin wr(2'd0, XLEN'(i)); wr(2'd1, '0); end
    check_flags("R8 all clear");
    wr(2'd0, 32'd3); wr(2'd1, 32'h4); check_flags("R8 execute on 3");
    wr(2'd0, 32'd1); wr(2'd1, 32'h1); check_flags("R9 load on 1");
    wr(2'd0, 32'd2); wr(2'd1, 32'h2); check_flags("R9 store on 2");
    wr(2'd0, 32'd3); wr(2'd1, 32'h0); check_flags("R8 execute cleared");
    wr(2'd0, 32'd1); wr(2'd1, 32'h0); check_flags("R9 load cleared");
  endtask

  task automatic t_flush();
    wr(2'd0, 32'd0);
    check("R10 no flush on select", XLEN'(flush_req), '0);
    wr(2'd1, 32'h10);
    check("R10 flush after write", XLEN'(flush_req), 32'd1);
    @(negedge clk);
    check("R10 flush one cycle", XLEN'(flush_req), '0);
  endtask

  initial begin
    for (int i = 0; i < NTRIG; i++) begin m_ctl[i] = '0; m_cmp[i] = '0; end
    m_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_ctl_fields();
    t_readonly();
    t_compare();
    t_isolation();
    t_out_of_range();
    t_flags();
    t_flush();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule